// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the iterative multiply and divide engine of a load-store integer core, and it owns the two architectural result registers HI and LO. The core issues an operation by pulsing a start strobe with two 32-bit register operands and a 2-bit operation code. The code selects signed or unsigned multiply or divide. The unit processes one operand bit per cycle. When it finishes, it writes either the full 64-bit product or the quotient and remainder into HI and LO, and it pulses a done flag.

The register-move instructions that read HI and LO go through a read port. The port returns the selected register combinationally. While an operation is in flight, a read request raises a stall output, so the pipeline holds the read until the result is final. A start that arrives while the unit is working is dropped.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: Operation code `op_i` = 2'b01 (unsigned multiply) writes the upper half of the unsigned 64-bit product of `opa_i` and `opb_i` into HI and the lower half into LO.
- R2: `op_i` = 2'b00 (signed multiply) writes the two's-complement 64-bit product, upper half to HI and lower half to LO.
- R3: `op_i` = 2'b11 (unsigned divide) writes `opa_i / opb_i` into LO and `opa_i % opb_i` into HI.
- R4: `op_i` = 2'b10 (signed divide) writes the quotient truncated toward zero into LO and the remainder into HI. The remainder carries the sign of the dividend, and 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: A divide by zero, signed or unsigned, completes normally with LO = 0xFFFFFFFF and HI equal to the dividend.
- R6: A start accepted at a clock edge raises `busy_o` after that edge. `busy_o` stays high for 33 cycles. `done_o` is high for exactly the one cycle after `busy_o` falls, and HI and LO hold the new result from that cycle on.
- R7: A start while `busy_o` is high is ignored: neither the running operation nor its timing changes.
- R8: `rd_data_o` shows HI when `rd_sel_hi_i` = 1 and LO when `rd_sel_hi_i` = 0, in the same cycle.
- R9: `stall_o` is high exactly when `rd_req_i` is high while `busy_o` is high.
- R10: After reset, HI and LO are zero and `busy_o`, `done_o` and `stall_o` are low.
- R11: HI and LO change only in the cycle in which `done_o` rises. Reads and operand changes without an accepted start leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | Bit 1: divide; bit 0: unsigned |
| opa_i | input | 32 | Multiplier or dividend |
| opb_i | input | 32 | Multiplicand or divisor |
| rd_req_i | input | 1 | Read request for HI or LO |
| rd_sel_hi_i | input | 1 | 1 reads HI, 0 reads LO |
| rd_data_o | output | 32 | Selected result register |
| busy_o | output | 1 | Operation in flight |
| stall_o | output | 1 | Read request must wait |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted iteration counter shows up at the ports as a `done_o` pulse that comes too early or too late, or never comes. The bench measures the exact edge of that pulse on every operation. A wrong accumulator bit or a stale sign flag appears as a wrong HI or LO word in the cycle after `done_o`, and the bench reads both words through the read port at that point. A write enable that leaks outside completion appears as a HI/LO word that drifts during idle cycles. The hold checks and the bound checker catch that drift one cycle after it happens.

// File: rtl/hilo_pkg.sv
// Package: shared operation encoding for the HI/LO multiply-divide unit.
// The two code bits match the low bits of the register-format function codes.
package hilo_pkg;
    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } mdu_op_e;
endpackage

// File: rtl/hilo_operand_prep.sv
// Module: hilo_operand_prep
// Converts two operands to magnitudes for the unsigned loop and reports
// which operands were negative. Assumes two's-complement inputs; in unsigned
// mode both operands pass through unchanged and are never flagged negative.
module hilo_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_a_o,
    output logic         neg_b_o
);
    // Sign detection and magnitude selection.
    always_comb begin
        neg_a_o = signed_i & a_i[W-1];
        neg_b_o = signed_i & b_i[W-1];
        mag_a_o = neg_a_o ? (~a_i + 1'b1) : a_i;
        mag_b_o = neg_b_o ? (~b_i + 1'b1) : b_i;
    end
endmodule

// File: rtl/hilo_iter_core.sv
// Module: hilo_iter_core
// Unsigned bit-serial engine. For a multiply it runs shift-add; for a divide
// it runs restoring division. Each does W steps, one per cycle. After the last
// step it asserts fin_o for one cycle while still running. Assumes load_i is
// only honoured while idle; a zero divisor needs no special case, because
// every trial subtract then succeeds.
module hilo_iter_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         is_div_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic         run_o,
    output logic         fin_o,
    output logic [W-1:0] acc_hi_o,
    output logic [W-1:0] acc_lo_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic          run_q, div_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  hi_q, lo_q, opd_q;
    logic [W:0]    sum, mul_hi, shifted;
    logic          fits;
    logic [W-1:0]  nxt_hi, nxt_lo;

    // One multiply or divide step computed from the current accumulators.
    always_comb begin
        sum     = {1'b0, hi_q} + {1'b0, opd_q};
        mul_hi  = lo_q[0] ? sum : {1'b0, hi_q};
        shifted = {hi_q, lo_q[W-1]};
        fits    = shifted >= {1'b0, opd_q};
        if (div_q) begin
            nxt_hi = fits ? (shifted[W-1:0] - opd_q) : shifted[W-1:0];
            nxt_lo = {lo_q[W-2:0], fits};
        end else begin
            nxt_hi = mul_hi[W:1];
            nxt_lo = {mul_hi[0], lo_q[W-1:1]};
        end
    end

    // Load, step and step-count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= 1'b0;
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            opd_q <= '0;
        end else if (load_i && !run_q) begin
            run_q <= 1'b1;
            div_q <= is_div_i;
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= mag_a_i;
            opd_q <= mag_b_i;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
            end else begin
                hi_q  <= nxt_hi;
                lo_q  <= nxt_lo;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run_o    = run_q;
    assign fin_o    = run_q && (cnt_q == LAST);
    assign acc_hi_o = hi_q;
    assign acc_lo_o = lo_q;
endmodule

// File: rtl/hilo_sign_fix.sv
// Module: hilo_sign_fix
// Restores signs on the unsigned engine result. A product is negated when
// the operand signs differ. A quotient is negated when the signs differ and
// the divisor is non-zero. A remainder follows the dividend's sign. Assumes
// the sign flags were captured with the operands.
module hilo_sign_fix #(
    parameter int W = 32
) (
    input  logic         is_div_i,
    input  logic         neg_a_i,
    input  logic         neg_b_i,
    input  logic         b_zero_i,
    input  logic [W-1:0] acc_hi_i,
    input  logic [W-1:0] acc_lo_i,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;

    // Sign correction for both result kinds, then selection by operation.
    always_comb begin
        prod = {acc_hi_i, acc_lo_i};
        if (neg_a_i ^ neg_b_i) prod = ~prod + 1'b1;
        quo = ((neg_a_i ^ neg_b_i) && !b_zero_i) ? (~acc_lo_i + 1'b1) : acc_lo_i;
        rem = neg_a_i ? (~acc_hi_i + 1'b1) : acc_hi_i;
        if (is_div_i) begin
            res_hi_o = rem;
            res_lo_o = quo;
        end else begin
            res_hi_o = prod[2*W-1:W];
            res_lo_o = prod[W-1:0];
        end
    end
endmodule

// File: rtl/hilo_muldiv_unit.sv
// Module: hilo_muldiv_unit (top)
// Owns HI and LO, accepts a start while idle, runs the iterative engine,
// writes the sign-corrected result on completion and serves register reads,
// stalling them while busy. Assumes the pipeline holds a stalled read.
module hilo_muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         rd_req_i,
    input  logic         rd_sel_hi_i,
    output logic [W-1:0] rd_data_o,
    output logic         busy_o,
    output logic         stall_o,
    output logic         done_o
);
    import hilo_pkg::*;

    mdu_op_e      op;
    logic         is_div, is_signed, accept;
    logic [W-1:0] mag_a, mag_b, acc_hi, acc_lo, res_hi, res_lo;
    logic         neg_a, neg_b, run, fin;
    logic         div_q, neg_a_q, neg_b_q, bzero_q, done_q;
    logic [W-1:0] hi_q, lo_q;

    // Decode the operation code.
    always_comb begin
        op        = mdu_op_e'(op_i);
        is_div    = (op == OP_DIVS) || (op == OP_DIVU);
        is_signed = (op == OP_MULS) || (op == OP_DIVS);
        accept    = start_i && !run;
    end

    hilo_operand_prep #(.W(W)) u_prep (
        .a_i(opa_i), .b_i(opb_i), .signed_i(is_signed),
        .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_a_o(neg_a), .neg_b_o(neg_b)
    );

    hilo_iter_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .is_div_i(is_div),
        .mag_a_i(mag_a), .mag_b_i(mag_b), .run_o(run), .fin_o(fin),
        .acc_hi_o(acc_hi), .acc_lo_o(acc_lo)
    );

    hilo_sign_fix #(.W(W)) u_fix (
        .is_div_i(div_q), .neg_a_i(neg_a_q), .neg_b_i(neg_b_q), .b_zero_i(bzero_q),
        .acc_hi_i(acc_hi), .acc_lo_i(acc_lo), .res_hi_o(res_hi), .res_lo_o(res_lo)
    );

    // Capture the sign context of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= 1'b0;
            neg_a_q <= 1'b0;
            neg_b_q <= 1'b0;
            bzero_q <= 1'b0;
        end else if (accept) begin
            div_q   <= is_div;
            neg_a_q <= neg_a;
            neg_b_q <= neg_b;
            bzero_q <= (opb_i == '0);
        end
    end

    // Architectural HI/LO write and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                hi_q <= res_hi;
                lo_q <= res_lo;
            end
        end
    end

    assign rd_data_o = rd_sel_hi_i ? hi_q : lo_q;
    assign busy_o    = run;
    assign stall_o   = rd_req_i && run;
    assign done_o    = done_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
// Module: hilo_muldiv_chk
// Protocol checker for hilo_muldiv_unit, attached by bind. Checks start
// acceptance, the done pulse, stall behaviour and HI/LO stability.
module hilo_muldiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         rd_req_i,
    input logic         busy_o,
    input logic         stall_o,
    input logic         done_o,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    // R6: an idle start makes the unit busy on the next cycle.
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R6: done lasts one cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: done follows a busy cycle and is never seen with busy.
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R9: a read while busy stalls.
    p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && busy_o) |-> stall_o);
    // R9: no stall when idle.
    p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !stall_o);
    // R11: HI/LO only move with completion.
    p_hilo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind hilo_muldiv_unit hilo_muldiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_i(rd_req_i),
    .busy_o(busy_o), .stall_o(stall_o), .done_o(done_o),
    .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_hilo_muldiv_unit.sv
// Directed bench for hilo_muldiv_unit: one task per scenario.
module test_hilo_muldiv_unit;
    localparam int W   = 32;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         rd_req_i = 1'b0;
    logic         rd_sel_hi_i = 1'b0;
    logic [W-1:0] rd_data_o;
    logic         busy_o, stall_o, done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hilo_muldiv_unit #(.W(W)) i_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .rd_req_i(rd_req_i),
        .rd_sel_hi_i(rd_sel_hi_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .stall_o(stall_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_hilo(output logic [W-1:0] hi, output logic [W-1:0] lo);
        rd_sel_hi_i = 1'b1; #0.5; hi = rd_data_o;
        rd_sel_hi_i = 1'b0; #0.5; lo = rd_data_o;
    endtask

    // Issue one operation, check latency, the done pulse and the result (R6, R8).
    task automatic run_op(input string req, input logic [1:0] op,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] exp_hi, input logic [W-1:0] exp_lo);
        int lat;
        logic [W-1:0] hi, lo;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R6", "busy after start", W'(busy_o), W'(1));
        lat = 0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R6", "done latency", W'(lat), W'(LAT));
        check("R6", "busy low at done", W'(busy_o), W'(0));
        read_hilo(hi, lo);
        check(req, "HI", hi, exp_hi);
        check(req, "LO", lo, exp_lo);
        @(negedge clk);
        check("R6", "done one cycle", W'(done_o), W'(0));
    endtask

    task automatic t_reset;
        logic [W-1:0] hi, lo;
        rd_req_i = 1'b1;
        #0.5;
        check("R10", "busy", W'(busy_o), W'(0));
        check("R10", "done", W'(done_o), W'(0));
        check("R10", "stall", W'(stall_o), W'(0));
        read_hilo(hi, lo);
        check("R10", "HI", hi, '0);
        check("R10", "LO", lo, '0);
        rd_req_i = 1'b0;
    endtask

    task automatic t_mul_unsigned;
        logic [2*W-1:0] p;
        logic [W-1:0] a [3] = '{32'hFFFF_FFFF, 32'h1234_5678, 32'h0};
        logic [W-1:0] b [3] = '{32'hFFFF_FFFF, 32'h9ABC_DEF0, 32'h5};
        for (int i = 0; i < 3; i++) begin
            p = {32'h0, a[i]} * {32'h0, b[i]};
            run_op("R1", 2'b01, a[i], b[i], p[2*W-1:W], p[W-1:0]);
        end
    endtask

    task automatic t_mul_signed;
        longint p;
        logic [W-1:0] a [4] = '{32'hFFFF_FFFD, 32'h8000_0000, 32'h5, 32'hFFFF_FFFF};
        logic [W-1:0] b [4] = '{32'h7, 32'h8000_0000, 32'hFFFF_FFF7, 32'hFFFF_FFFF};
        for (int i = 0; i < 4; i++) begin
            p = longint'($signed(a[i])) * longint'($signed(b[i]));
            run_op("R2", 2'b00, a[i], b[i], p[63:32], p[31:0]);
        end
    endtask

    task automatic t_div_unsigned;
        logic [W-1:0] a [3] = '{32'd100, 32'hFFFF_FFFF, 32'd5};
        logic [W-1:0] b [3] = '{32'd7, 32'd3, 32'd9};
        for (int i = 0; i < 3; i++)
            run_op("R3", 2'b11, a[i], b[i], a[i] % b[i], a[i] / b[i]);
    endtask

    task automatic t_div_signed;
        longint q, r;
        logic [W-1:0] a [4] = '{32'hFFFF_FFF9, 32'h7, 32'hFFFF_FFF9, 32'h8000_0000};
        logic [W-1:0] b [4] = '{32'h2, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF};
        for (int i = 0; i < 4; i++) begin
            q = longint'($signed(a[i])) / longint'($signed(b[i]));
            r = longint'($signed(a[i])) % longint'($signed(b[i]));
            run_op("R4", 2'b10, a[i], b[i], r[31:0], q[31:0]);
        end
    endtask

    task automatic t_div_zero;
        run_op("R5", 2'b11, 32'd1234, 32'd0, 32'd1234, 32'hFFFF_FFFF);
        run_op("R5", 2'b10, 32'hFFFF_FFFB, 32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFF);
    endtask

    // R7: a second start during the run changes neither timing nor result.
    task automatic t_ignore_start;
        int lat;
        logic [W-1:0] hi, lo;
        @(negedge clk);
        op_i = 2'b01; opa_i = 32'd3; opb_i = 32'd4; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; lat = 0;
        repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
        op_i = 2'b11; opa_i = 32'd100; opb_i = 32'd7; start_i = 1'b1;
        @(posedge clk); lat++; @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R7", "latency kept", W'(lat), W'(LAT));
        read_hilo(hi, lo);
        check("R7", "HI of first op", hi, 32'd0);
        check("R7", "LO of first op", lo, 32'd12);
        @(negedge clk);
        check("R7", "no restart", W'(busy_o), W'(0));
    endtask

    // R9: stall tracks read requests while busy.
    task automatic t_stall;
        @(negedge clk);
        op_i = 2'b11; opa_i = 32'd50; opb_i = 32'd5; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        rd_req_i = 1'b1; #0.5;
        check("R9", "stall while busy", W'(stall_o), W'(1));
        rd_req_i = 1'b0; #0.5;
        check("R9", "no stall without request", W'(stall_o), W'(0));
        rd_req_i = 1'b1;
        while (!done_o) @(negedge clk);
        #0.5;
        check("R9", "no stall when done", W'(stall_o), W'(0));
        rd_req_i = 1'b0;
    endtask

    // R11: reads and operand changes without start leave HI/LO alone.
    task automatic t_hold;
        logic [W-1:0] hi0, lo0, hi, lo;
        read_hilo(hi0, lo0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            opa_i = 32'(i * 77); opb_i = 32'(i + 1); op_i = 2'(i);
            rd_req_i = i[0]; rd_sel_hi_i = i[1];
        end
        @(negedge clk);
        rd_req_i = 1'b0;
        read_hilo(hi, lo);
        check("R11", "HI held", hi, hi0);
        check("R11", "LO held", lo, lo0);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mul_unsigned();
        t_mul_signed();
        t_div_unsigned();
        t_div_signed();
        t_div_zero();
        t_ignore_start();
        t_stall();
        t_hold();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule